// File: doc/BRIEF.md
# Chunked Cipher Job Sequencer

This block sits in front of a block-cipher engine that can only work on data held in a small local working buffer. It takes cipher requests of up to 2^16-1 bytes from a queue. It splits each request into chunks that fit the data area of that buffer. For each chunk it does four things in turn:

- moves the chunk's input bytes from a byte stream into the buffer;
- presents a chunk descriptor to the engine;
- starts the engine and waits for its done pulse;
- reads the processed bytes back out of the buffer onto an output byte stream.

The engine itself and its key handling are outside the block.

The buffer is split into a 0x50-byte header area and a data area. The chained-IV slot lives at offsets 0x40..0x4F. Chunk data starts at offset 0x50. A three-state tracker (idle, busy, waiting for drain) is visible on a port and governs when new work may start and when a done pulse is honoured. In chaining (CBC) mode the IV is loaded into the buffer once per request, before the first chunk. At the end of the request the IV that the engine left in the buffer is read back and returned with the completion. A per-chunk watchdog aborts a chunk whose done pulse never arrives.

Top module: `chunk_cipher_seq`

## Requirements
- R1: `eng_state` encodes the tracker as 0 = idle, 1 = busy, 2 = waiting for drain. A queued request is taken only while idle, and taking it moves the tracker to busy. `eng_start` is only ever issued while busy.
- R2: `eng_done` moves the tracker from busy to waiting-for-drain only while a chunk is running. A done pulse at any other time, for example while idle, produces no output and leaves the tracker unchanged. Buffer reads of chunk data occur only while waiting for drain.
- R3: Each chunk's length, shown on `eng_len` with the one-cycle `eng_start` pulse, is the smaller of the bytes still left in the request and BUF_BYTES-0x50 (48 with defaults). Input bytes of a chunk are written to buffer offsets 0x50, 0x51, ... in arrival order.
- R4: After `eng_done`, the chunk's bytes are read from offsets 0x50 upward and appear on `out_data` in the same order, one per `out_valid` cycle. If request bytes remain, the tracker returns to busy and the next chunk is loaded. Otherwise the tracker returns to idle and `done_valid` pulses for one cycle with `done_err` low.
- R5: In CBC mode (`req_cbc`=1) the 16 IV bytes are written to offsets 0x40..0x4F only before the first chunk of a request. Byte k, written at 0x40+k, is `req_iv[127-8k -: 8]`. Later chunks leave the IV slot to the engine.
- R6: At CBC completion `done_iv` carries the 16 bytes read from 0x40..0x4F, in the same byte order as R5. In ECB mode `done_iv` is zero and the IV slot is neither written nor read.
- R7: Up to 50 requests wait in a queue in front of the request being processed. `req_ready` is low while the queue is full. Requests are served in arrival order.
- R8: A request whose length is zero or not a multiple of 16 is rejected. `req_rej` pulses one cycle after its handshake, and the request is never issued to the engine.
- R9: If `eng_done` has not arrived `wd_limit` cycles after a chunk starts, the request ends with a `done_valid` pulse carrying `done_err`=1 and `done_iv`=0, and the tracker returns to idle.
- R10: `eng_cbc` and `eng_dec` carry the mode and direction of the request the chunk belongs to.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wd_limit | input | WD_W | Cycles allowed per chunk before abort |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Queue has room |
| req_len | input | LEN_W | Request length in bytes |
| req_cbc | input | 1 | 1 = CBC chaining, 0 = ECB |
| req_dec | input | 1 | 1 = decrypt, 0 = encrypt |
| req_iv | input | 128 | Initial vector for CBC |
| req_rej | output | 1 | Pulse: request rejected for bad length |
| in_valid | input | 1 | Input byte present |
| in_ready | output | 1 | Sequencer takes an input byte |
| in_data | input | 8 | Input byte |
| out_valid | output | 1 | Output byte valid |
| out_data | output | 8 | Output byte |
| buf_we | output | 1 | Buffer write enable |
| buf_re | output | 1 | Buffer read enable (data one cycle later) |
| buf_addr | output | AW | Buffer byte address |
| buf_wdata | output | 8 | Buffer write data |
| buf_rdata | input | 8 | Buffer read data |
| eng_start | output | 1 | Pulse: engine starts a chunk |
| eng_len | output | LEN_W | Chunk length for the engine |
| eng_cbc | output | 1 | Chunk mode |
| eng_dec | output | 1 | Chunk direction |
| eng_done | input | 1 | Engine finished the chunk |
| eng_state | output | 2 | Tracker state |
| done_valid | output | 1 | Pulse: request complete |
| done_err | output | 1 | Completion was a watchdog abort |
| done_iv | output | 128 | Returned chained IV (CBC) |

## Verification
Suppose the tracker is left in the wrong state. A lost or early transition to waiting-for-drain shows as a missing output byte, or a byte read before the engine transformed it. Either one appears within one chunk at `out_data`. A wrong chunk count or a wrong remaining-byte total shows at the very next `eng_start` as a bad `eng_len`. A stale or re-written IV slot shows only at request completion, as a wrong `done_iv`. The bench's engine model advances the IV slot once per chunk, so the returned IV also encodes how many chunks ran and whether the IV was reloaded mid-request.

// File: rtl/ccs_pkg.sv
package ccs_pkg;
  // tracker state as seen on the eng_state port
  typedef enum logic [1:0] {
    TRK_IDLE = 2'd0,
    TRK_BUSY = 2'd1,
    TRK_WAIT = 2'd2
  } trk_e;

  // internal sequencing phase
  typedef enum logic [2:0] {
    PH_IDLE, PH_FETCH, PH_IV, PH_LOAD, PH_GO, PH_RUN, PH_DRAIN, PH_IVRD
  } phase_e;

  localparam int IV_BYTES  = 16;
  localparam int BLK_BYTES = 16;
  localparam int IV_OFS    = 64;  // chained-IV slot
  localparam int HDR_BYTES = 80;  // data area begins here
endpackage

// File: rtl/ccs_req_fifo.sv
module ccs_req_fifo #(
  parameter int DEPTH = 50,
  parameter int W     = 146
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         push,
  input  logic [W-1:0] din,
  input  logic         pop,
  output logic [W-1:0] dout,
  output logic         full,
  output logic         empty
);
  localparam int PW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [PW-1:0] LAST = PW'(DEPTH - 1);

  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] wr_ptr, rd_ptr;
  logic [CW-1:0] cnt;

  assign full  = (cnt == CW'(DEPTH));
  assign empty = (cnt == '0);

  // storage without reset, synchronous read: block RAM friendly
  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr] <= din;
    if (pop)  dout <= mem[rd_ptr];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      cnt    <= '0;
    end else begin
      if (push) wr_ptr <= (wr_ptr == LAST) ? '0 : wr_ptr + PW'(1);
      if (pop)  rd_ptr <= (rd_ptr == LAST) ? '0 : rd_ptr + PW'(1);
      case ({push, pop})
        2'b10:   cnt <= cnt + CW'(1);
        2'b01:   cnt <= cnt - CW'(1);
        default: cnt <= cnt;
      endcase
    end
  end

  AST_FIFO_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (rst) pop |-> !empty); // R7
  AST_FIFO_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst) push |-> !full); // R7
  AST_FIFO_COUNT_MAX: assert property (@(posedge clk) disable iff (rst) cnt <= CW'(DEPTH)); // R7
endmodule

// File: rtl/ccs_watchdog.sv
module ccs_watchdog #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         run,
  input  logic [W-1:0] limit,
  output logic         expired
);
  logic [W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || !run)      cnt <= '0;
    else if (cnt != limit) cnt <= cnt + W'(1);
  end

  assign expired = run && (cnt == limit);

  AST_WD_CLEARS_IDLE: assert property (@(posedge clk) disable iff (rst) !run |=> cnt == '0); // R9
endmodule

// File: rtl/chunk_cipher_seq.sv
module chunk_cipher_seq
  import ccs_pkg::*;
#(
  parameter int BUF_BYTES = 128,
  parameter int QDEPTH    = 50,
  parameter int LEN_W     = 16,
  parameter int WD_W      = 16,
  localparam int AW       = $clog2(BUF_BYTES)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [WD_W-1:0]   wd_limit,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [LEN_W-1:0]  req_len,
  input  logic              req_cbc,
  input  logic              req_dec,
  input  logic [127:0]      req_iv,
  output logic              req_rej,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [7:0]        in_data,
  output logic              out_valid,
  output logic [7:0]        out_data,
  output logic              buf_we,
  output logic              buf_re,
  output logic [AW-1:0]     buf_addr,
  output logic [7:0]        buf_wdata,
  input  logic [7:0]        buf_rdata,
  output logic              eng_start,
  output logic [LEN_W-1:0]  eng_len,
  output logic              eng_cbc,
  output logic              eng_dec,
  input  logic              eng_done,
  output logic [1:0]        eng_state,
  output logic              done_valid,
  output logic              done_err,
  output logic [127:0]      done_iv
);
  localparam int CAP = BUF_BYTES - HDR_BYTES;
  localparam int QW  = LEN_W + 2 + 128;
  localparam logic [LEN_W-1:0] ONE     = LEN_W'(1);
  localparam logic [LEN_W-1:0] CAP_L   = LEN_W'(CAP);
  localparam logic [LEN_W-1:0] IV_N    = LEN_W'(IV_BYTES);
  localparam logic [LEN_W-1:0] BLK_MSK = LEN_W'(BLK_BYTES - 1);
  localparam logic [AW-1:0]    IV_A    = AW'(IV_OFS);
  localparam logic [AW-1:0]    DATA_A  = AW'(HDR_BYTES);

  phase_e ph;
  trk_e   trk;

  logic [LEN_W-1:0] rem, chunk, wr_cnt, rd_cnt, rx_cnt;
  logic             cbc_q, dec_q, started, pipe1;
  logic [127:0]     iv_sh, iv_acc;

  // request queue
  logic          q_push, q_pop, q_full, q_empty, len_ok;
  logic [QW-1:0] q_dout;

  assign len_ok    = (req_len != '0) && ((req_len & BLK_MSK) == '0);
  assign req_ready = !q_full;
  assign q_push    = req_valid && req_ready && len_ok;
  assign q_pop     = (ph == PH_IDLE) && !q_empty;

  ccs_req_fifo #(.DEPTH(QDEPTH), .W(QW)) u_fifo (
    .clk(clk), .rst(rst), .push(q_push),
    .din({req_len, req_cbc, req_dec, req_iv}),
    .pop(q_pop), .dout(q_dout), .full(q_full), .empty(q_empty)
  );

  // per-chunk watchdog
  logic wd_expired;
  ccs_watchdog #(.W(WD_W)) u_wd (
    .clk(clk), .rst(rst), .run(ph == PH_RUN), .limit(wd_limit), .expired(wd_expired)
  );

  assign chunk     = (rem < CAP_L) ? rem : CAP_L;
  assign in_ready  = (ph == PH_LOAD);
  assign eng_state = trk;

  always_ff @(posedge clk) begin
    if (rst) begin
      ph <= PH_IDLE;  trk <= TRK_IDLE;
      rem <= '0; wr_cnt <= '0; rd_cnt <= '0; rx_cnt <= '0;
      cbc_q <= 1'b0; dec_q <= 1'b0; started <= 1'b0; pipe1 <= 1'b0;
      iv_sh <= '0; iv_acc <= '0;
      req_rej <= 1'b0; out_valid <= 1'b0; out_data <= '0;
      buf_we <= 1'b0; buf_re <= 1'b0; buf_addr <= '0; buf_wdata <= '0;
      eng_start <= 1'b0; eng_len <= '0; eng_cbc <= 1'b0; eng_dec <= 1'b0;
      done_valid <= 1'b0; done_err <= 1'b0; done_iv <= '0;
    end else begin
      buf_we     <= 1'b0;
      buf_re     <= 1'b0;
      eng_start  <= 1'b0;
      done_valid <= 1'b0;
      req_rej    <= req_valid && req_ready && !len_ok;
      pipe1      <= buf_re;
      out_valid  <= pipe1 && (ph == PH_DRAIN);
      out_data   <= buf_rdata;

      case (ph)
        PH_IDLE: if (!q_empty) begin
          ph  <= PH_FETCH;
          trk <= TRK_BUSY;
        end
        PH_FETCH: begin
          rem     <= q_dout[QW-1 -: LEN_W];
          cbc_q   <= q_dout[129];
          dec_q   <= q_dout[128];
          iv_sh   <= q_dout[127:0];
          started <= 1'b0;
          wr_cnt  <= '0;
          ph      <= q_dout[129] ? PH_IV : PH_LOAD;
        end
        PH_IV: begin
          buf_we    <= 1'b1;
          buf_addr  <= IV_A + AW'(wr_cnt);
          buf_wdata <= iv_sh[127:120];
          iv_sh     <= {iv_sh[119:0], 8'h00};
          if (wr_cnt == IV_N - ONE) begin
            wr_cnt <= '0;
            ph     <= PH_LOAD;
          end else wr_cnt <= wr_cnt + ONE;
        end
        PH_LOAD: if (in_valid) begin
          buf_we    <= 1'b1;
          buf_addr  <= DATA_A + AW'(wr_cnt);
          buf_wdata <= in_data;
          if (wr_cnt == chunk - ONE) begin
            wr_cnt <= '0;
            ph     <= PH_GO;
          end else wr_cnt <= wr_cnt + ONE;
        end
        PH_GO: begin
          eng_start <= 1'b1;
          eng_len   <= chunk;
          eng_cbc   <= cbc_q;
          eng_dec   <= dec_q;
          started   <= 1'b1;
          ph        <= PH_RUN;
        end
        PH_RUN: begin
          if (eng_done) begin
            trk    <= TRK_WAIT;
            ph     <= PH_DRAIN;
            rd_cnt <= '0;
            rx_cnt <= '0;
          end else if (wd_expired) begin
            done_valid <= 1'b1;
            done_err   <= 1'b1;
            done_iv    <= '0;
            trk        <= TRK_IDLE;
            ph         <= PH_IDLE;
          end
        end
        PH_DRAIN: begin
          if (rd_cnt < chunk) begin
            buf_re   <= 1'b1;
            buf_addr <= DATA_A + AW'(rd_cnt);
            rd_cnt   <= rd_cnt + ONE;
          end
          if (pipe1) begin
            rx_cnt <= rx_cnt + ONE;
            if (rx_cnt == chunk - ONE) begin
              rd_cnt <= '0;
              rx_cnt <= '0;
              rem    <= rem - chunk;
              if (rem != chunk) begin
                trk <= TRK_BUSY;
                ph  <= PH_LOAD;
              end else if (cbc_q) begin
                ph <= PH_IVRD;
              end else begin
                done_valid <= 1'b1;
                done_err   <= 1'b0;
                done_iv    <= '0;
                trk        <= TRK_IDLE;
                ph         <= PH_IDLE;
              end
            end
          end
        end
        PH_IVRD: begin
          if (rd_cnt < IV_N) begin
            buf_re   <= 1'b1;
            buf_addr <= IV_A + AW'(rd_cnt);
            rd_cnt   <= rd_cnt + ONE;
          end
          if (pipe1) begin
            iv_acc <= {iv_acc[119:0], buf_rdata};
            rx_cnt <= rx_cnt + ONE;
            if (rx_cnt == IV_N - ONE) begin
              done_valid <= 1'b1;
              done_err   <= 1'b0;
              done_iv    <= {iv_acc[119:0], buf_rdata};
              trk        <= TRK_IDLE;
              ph         <= PH_IDLE;
            end
          end
        end
        default: ph <= PH_IDLE;
      endcase
    end
  end

  AST_START_IN_BUSY: assert property (@(posedge clk) disable iff (rst) eng_start |-> trk == TRK_BUSY); // R1
  AST_WAIT_NEEDS_DONE: assert property (@(posedge clk) disable iff (rst) (trk == TRK_WAIT && $past(trk) != TRK_WAIT) |-> $past(eng_done)); // R2
  AST_CHUNK_BOUND: assert property (@(posedge clk) disable iff (rst) eng_start |-> (eng_len != '0 && eng_len <= CAP_L)); // R3
  AST_DONE_AT_IDLE: assert property (@(posedge clk) disable iff (rst) done_valid |-> trk == TRK_IDLE); // R4
  AST_IV_FIRST_ONLY: assert property (@(posedge clk) disable iff (rst) (buf_we && buf_addr >= IV_A && buf_addr < DATA_A) |-> !started); // R5
  AST_ECB_IV_ZERO: assert property (@(posedge clk) disable iff (rst) (done_valid && !cbc_q) |-> done_iv == '0); // R6
  AST_REJ_AFTER_OFFER: assert property (@(posedge clk) disable iff (rst) req_rej |-> $past(req_valid && req_ready)); // R8
endmodule

// File: tb/chunk_cipher_seq_bench.sv
module chunk_cipher_seq_bench;
  localparam int LW   = 16;
  localparam int BUFB = 128;
  localparam int AWB  = 7;
  localparam int CAPB = 48;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic            rst = 1'b1;
  logic [15:0]     wd_limit = 16'd40;
  logic            req_valid = 1'b0, req_cbc = 1'b0, req_dec = 1'b0;
  logic [LW-1:0]   req_len = '0;
  logic [127:0]    req_iv = '0;
  logic            req_ready, req_rej, in_ready, out_valid;
  logic            in_valid = 1'b0;
  logic [7:0]      in_data = '0, out_data, buf_wdata, buf_rdata;
  logic            buf_we, buf_re, eng_start, eng_cbc, eng_dec;
  logic [AWB-1:0]  buf_addr;
  logic [LW-1:0]   eng_len;
  logic [1:0]      eng_state;
  logic            done_valid, done_err;
  logic [127:0]    done_iv;
  logic            eng_done, eng_done_r = 1'b0, spur = 1'b0;

  assign eng_done = eng_done_r | spur;

  chunk_cipher_seq u_chunk_cipher_seq (
    .clk(clk), .rst(rst), .wd_limit(wd_limit),
    .req_valid(req_valid), .req_ready(req_ready), .req_len(req_len),
    .req_cbc(req_cbc), .req_dec(req_dec), .req_iv(req_iv), .req_rej(req_rej),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .out_valid(out_valid), .out_data(out_data),
    .buf_we(buf_we), .buf_re(buf_re), .buf_addr(buf_addr),
    .buf_wdata(buf_wdata), .buf_rdata(buf_rdata),
    .eng_start(eng_start), .eng_len(eng_len), .eng_cbc(eng_cbc), .eng_dec(eng_dec),
    .eng_done(eng_done), .eng_state(eng_state),
    .done_valid(done_valid), .done_err(done_err), .done_iv(done_iv)
  );

  int checks = 0, errors = 0;
  int rej_exp = 0, rej_seen = 0, ivw = 0, cbc_reqs = 0;

  logic [7:0]    exp_out[$];
  logic [128:0]  exp_done[$];
  logic [LW+1:0] exp_desc[$];
  logic [7:0]    in_q[$];
  bit            hold_data = 1'b0;
  bit            pend = 1'b0;

  task automatic chk(input bit ok, input string rq, input logic [128:0] act, input logic [128:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", rq, act, exp);
    end
  endtask

  // buffer and engine model: transform = xor 3C (plus 0F when decrypting),
  // CBC chunks advance each IV slot byte by one
  logic [7:0] mem [BUFB];
  int  eng_delay = 3;
  bit  eng_hang  = 1'b0;
  int  e_cnt = 0, e_len = 0;
  bit  e_cbc = 1'b0, e_dec = 1'b0;

  always @(posedge clk) begin
    if (buf_we) mem[buf_addr] <= buf_wdata;
    if (buf_re) buf_rdata <= mem[buf_addr];
    eng_done_r <= 1'b0;
    if (eng_hang) e_cnt <= 0;
    else if (eng_start) begin
      e_cnt <= eng_delay; e_len <= int'(eng_len); e_cbc <= eng_cbc; e_dec <= eng_dec;
    end else if (e_cnt == 1) begin
      for (int i = 0; i < e_len; i++) mem[80+i] <= mem[80+i] ^ 8'h3C ^ (e_dec ? 8'h0F : 8'h00);
      if (e_cbc) for (int k = 0; k < 16; k++) mem[64+k] <= mem[64+k] + 8'd1;
      eng_done_r <= 1'b1;
      e_cnt <= 0;
    end else if (e_cnt > 1) e_cnt <= e_cnt - 1;
  end

  // input stream feeder
  always @(negedge clk) begin
    if (pend) void'(in_q.pop_front());
    if (!hold_data && in_q.size() > 0) begin
      in_valid = 1'b1;
      in_data  = in_q[0];
    end else in_valid = 1'b0;
    pend = in_valid && in_ready;
  end

  // monitor / scoreboard
  always @(negedge clk) begin
    if (!rst) begin
      if (out_valid) begin
        if (exp_out.size() == 0) chk(0, "R4", {121'd0, out_data}, 0);
        else begin
          logic [7:0] e;
          e = exp_out.pop_front();
          chk(out_data == e, "R4", {121'd0, out_data}, {121'd0, e});
        end
      end
      if (done_valid) begin
        if (exp_done.size() == 0) chk(0, "R2", {done_err, done_iv}, 0);
        else begin
          logic [128:0] e;
          e = exp_done.pop_front();
          chk({done_err, done_iv} == e, e[128] ? "R9" : "R6", {done_err, done_iv}, e);
        end
      end
      if (eng_start) begin
        chk(eng_state == 2'd1, "R1", {127'd0, eng_state}, 129'd1);
        if (exp_desc.size() == 0) chk(0, "R3", {111'd0, eng_len, eng_cbc, eng_dec}, 0);
        else begin
          logic [LW+1:0] e;
          e = exp_desc.pop_front();
          chk(eng_len == e[LW+1:2], "R3", {113'd0, eng_len}, {113'd0, e[LW+1:2]});
          chk({eng_cbc, eng_dec} == e[1:0], "R10", {127'd0, eng_cbc, eng_dec}, {127'd0, e[1:0]});
        end
      end
      if (buf_re && buf_addr >= AWB'(80))
        chk(eng_state == 2'd2, "R2", {127'd0, eng_state}, 129'd2);
      if (req_rej) rej_seen++;
      if (buf_we && buf_addr >= AWB'(64) && buf_addr < AWB'(80)) ivw++;
    end
  end

  task automatic send_req(input int len, input bit cbc, input bit dec,
                          input logic [127:0] iv, input int seed, input bit tmo);
    bit ok;
    ok = (len != 0) && (len % 16 == 0);
    if (ok) begin
      int rem;
      int nch;
      logic [127:0] ev;
      rem = len; nch = 0;
      while (rem > 0) begin
        int c;
        c = (rem < CAPB) ? rem : CAPB;
        exp_desc.push_back({LW'(c), cbc, dec});
        nch++; rem -= c;
        if (tmo) break;
      end
      for (int i = 0; i < len; i++) begin
        logic [7:0] d;
        d = 8'(seed + 7 * i);
        in_q.push_back(d);
        if (!tmo) exp_out.push_back(d ^ 8'h3C ^ (dec ? 8'h0F : 8'h00));
      end
      ev = '0;
      if (cbc) begin
        cbc_reqs++;
        for (int k = 0; k < 16; k++) ev[127-8*k -: 8] = iv[127-8*k -: 8] + 8'(nch);
      end
      exp_done.push_back(tmo ? {1'b1, 128'd0} : {1'b0, ev});
    end else rej_exp++;
    @(negedge clk);
    req_valid = 1'b1; req_len = LW'(len); req_cbc = cbc; req_dec = dec; req_iv = iv;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic wait_idle();
    while (exp_done.size() != 0 || exp_out.size() != 0) @(negedge clk);
    repeat (4) @(negedge clk);
    chk(eng_state == 2'd0, "R4", {127'd0, eng_state}, 0);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // reset state
    chk(eng_state == 2'd0, "R1", {127'd0, eng_state}, 0);
    chk(req_ready == 1'b1, "R7", {128'd0, req_ready}, 1);
    chk(!done_valid && !out_valid && !eng_start, "R4", {126'd0, done_valid, out_valid, eng_start}, 0);

    // single-chunk ECB encrypt
    eng_delay = 3;
    send_req(32, 1'b0, 1'b0, 128'h0, 11, 1'b0);
    wait_idle();

    // three-chunk CBC encrypt (48,48,16)
    eng_delay = 7;
    send_req(112, 1'b1, 1'b0, 128'h00112233_44556677_8899AABB_CCDDEEFF, 40, 1'b0);
    wait_idle();

    // exact-capacity CBC decrypt
    eng_delay = 2;
    send_req(48, 1'b1, 1'b1, 128'hF0E1D2C3_B4A59687_78695A4B_3C2D1E0F, 90, 1'b0);
    wait_idle();

    // two full chunks ECB decrypt
    send_req(96, 1'b0, 1'b1, 128'hFFFF, 5, 1'b0);
    wait_idle();

    // rejected lengths (R8)
    send_req(0, 1'b0, 1'b0, 128'h0, 0, 1'b0);
    send_req(20, 1'b1, 1'b0, 128'h0, 0, 1'b0);
    repeat (10) @(negedge clk);
    chk(rej_seen == rej_exp, "R8", 129'(rej_seen), 129'(rej_exp));
    chk(eng_state == 2'd0, "R8", {127'd0, eng_state}, 0);

    // done pulse while idle is ignored (R2)
    spur = 1'b1;
    @(negedge clk);
    spur = 1'b0;
    repeat (5) @(negedge clk);
    chk(eng_state == 2'd0, "R2", {127'd0, eng_state}, 0);

    // watchdog abort (R9), then recovery
    eng_hang = 1'b1;
    send_req(16, 1'b0, 1'b0, 128'h0, 77, 1'b1);
    wait_idle();
    eng_hang = 1'b0;
    send_req(16, 1'b1, 1'b1, 128'h0123, 33, 1'b0);
    wait_idle();

    // queue fill (R7): 1 in flight + 50 waiting
    hold_data = 1'b1;
    eng_delay = 1;
    for (int n = 0; n < 51; n++) send_req(16, n[0], 1'b0, 128'(n), 3 * n, 1'b0);
    repeat (3) @(negedge clk);
    chk(req_ready == 1'b0, "R7", {128'd0, req_ready}, 0);
    hold_data = 1'b0;
    wait_idle();
    chk(req_ready == 1'b1, "R7", {128'd0, req_ready}, 1);

    chk(ivw == 16 * cbc_reqs, "R5", 129'(ivw), 129'(16 * cbc_reqs));
    chk(exp_desc.size() == 0, "R3", 129'(exp_desc.size()), 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    chk(0, "R4 watchdog expired", 0, 1);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule